// File: doc/BRIEF.md
# Sized shift and rotate execution unit

This unit carries out the register forms of the shift and rotate instructions of a 32-bit processor with condition codes. A caller presents a 16-bit instruction word, the contents of the destination data register, the contents of a possible count register and the current condition codes, then pulses `start`. The unit decodes the word, then shifts or rotates the sized part of the operand by one bit per clock. It returns the new register value and the new five condition-code bits, and it names the register to write back.

Four operation kinds are supported: arithmetic shift, logical shift, rotate, and rotate through extend. Each works on a byte, word or long operand, in either direction. Only the bits inside the selected size move. The bits above the size come back exactly as they went in.

Control is a three-state machine. `ST_IDLE` waits for a start carrying an instruction word of the shift group. If the decoded count is zero it goes to `ST_FINISH`; otherwise it goes to `ST_STEP`. `ST_STEP` performs one single-bit step per cycle and moves to `ST_FINISH` on the last step. `ST_FINISH` raises `done` for one cycle and always returns to `ST_IDLE`.

Top module: `shrot_unit`

## Requirements
- R1: Instruction fields are decoded as follows:
  - bits 15–12 must be 1110, and a start carrying any other value there is ignored;
  - bits 11–9 hold the count or the count register, where an immediate 0 means 8;
  - bit 8 gives the direction, with 1 meaning left;
  - bits 7–6 give the size: 00 byte, 01 word, 10 long, and 11 also long;
  - bit 5 set means the count is taken from the count register;
  - bits 4–3 give the kind: 00 arithmetic, 01 logical, 10 rotate through extend, 11 rotate;
  - bits 2–0 are reported on `wb_reg`.
- R2: A count taken from the count register is its value modulo 64.
- R3: `result` bits above the selected size equal the corresponding bits of `opd`.
- R4: The start handshake behaves as follows:
  - a start is accepted only while `busy` is low;
  - `done` is high for exactly one cycle, count+1 cycles after the cycle in which the accepted start was presented;
  - after `done`, `busy` is low;
  - a start presented while `busy` is high is ignored.
- R5: `ccr_out` is {extend, negative, zero, overflow, carry} on bits 4..0. Negative is the top bit of the sized result, and zero is set when the sized result is all zeros.
- R6: For a logical or arithmetic shift by a non-zero count, extend and carry both equal the last bit shifted out. Overflow is 0, except as stated in R7.
- R7: An arithmetic left shift sets overflow when the top bit of the sized result differs from the top bit of the sized operand. An arithmetic right shift fills the vacated top positions with the operand's sign bit.
- R8: A rotate never changes extend. Carry equals the last bit rotated out, and overflow is 0.
- R9: A rotate through extend feeds the current extend into the vacated end on every step, then loads extend with the bit that left. At the end, carry equals extend.
- R10: With a count of zero the value is unchanged and extend keeps its input value. Carry is cleared for shifts and rotates, and is set equal to extend for rotate through extend.
- R11: After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the presented instruction |
| opcode | input | 16 | Instruction word |
| opd | input | 32 | Destination register contents |
| cnt_val | input | 32 | Count register contents |
| ccr_in | input | 5 | Condition codes before the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result and flags valid this cycle |
| result | output | 32 | New register value |
| ccr_out | output | 5 | New condition codes |
| wb_reg | output | 3 | Register to write back |

## Verification
The checker latches the instruction word, operand and extend bit only when a start is accepted. Its properties are therefore sound only if the caller holds `opd` and `ccr_in` at the values they had in that start cycle, and presents no second accepted start before `done`. The stimulus meets this by starting a new operation only after `busy` has fallen. Any start it drives while `busy` is high, or with a word outside the shift group, is a deliberate probe. The caller is never required to look at any output outside the `done` cycle.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [1:0] {
        K_ASH = 2'b00,
        K_LSH = 2'b01,
        K_ROX = 2'b10,
        K_ROT = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        SZ_B = 2'b00,
        SZ_W = 2'b01,
        SZ_L = 2'b10,
        SZ_X = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_FINISH
    } state_e;

    localparam int F_X = 4;
    localparam int F_N = 3;
    localparam int F_Z = 2;
    localparam int F_V = 1;
    localparam int F_C = 0;

    typedef struct packed {
        kind_e      kind;
        size_e      size;
        logic       left;
        logic [2:0] reg_idx;
    } dec_t;

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 6
) (
    input  logic [15:0]      opcode,
    input  logic [W-1:0]     cnt_val,
    output dec_t             dec,
    output logic [CNT_W-1:0] count,
    output logic             in_group
);
    localparam int         MOD = 1 << CNT_W;
    localparam logic [3:0] GRP = 4'hE;

    always_comb begin
        dec.kind    = kind_e'(opcode[4:3]);
        dec.size    = size_e'(opcode[7:6]);
        dec.left    = opcode[8];
        dec.reg_idx = opcode[2:0];
        in_group    = (opcode[15:12] == GRP);
        if (opcode[5])
            count = CNT_W'(cnt_val % W'(MOD));
        else if (opcode[11:9] == 3'd0)
            count = CNT_W'(8);
        else
            count = CNT_W'(opcode[11:9]);
    end
endmodule

// File: rtl/shrot_mask.sv
module shrot_mask
    import shrot_pkg::*;
#(
    parameter int W = 32
) (
    input  size_e        size,
    output logic [W-1:0] mask
);
    localparam int NS = 3;
    logic [W-1:0] lane [NS];

    for (genvar g = 0; g < NS; g++) begin : g_lane
        localparam int LW = ((8 << g) < W) ? (8 << g) : W;
        assign lane[g] = {W{1'b1}} >> (W - LW);
    end

    always_comb begin
        unique case (size)
            SZ_B:    mask = lane[0];
            SZ_W:    mask = lane[1];
            default: mask = lane[2];
        endcase
    end
endmodule

// File: rtl/shrot_step.sv
module shrot_step
    import shrot_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] mask,
    input  kind_e        kind,
    input  logic         left,
    input  logic         x_in,
    output logic [W-1:0] nxt,
    output logic         out_bit
);
    logic [W-1:0] top;
    logic         msbv;
    logic         fill;

    assign top  = mask ^ (mask >> 1);
    assign msbv = |(val & top);

    always_comb begin
        if (left) begin
            out_bit = msbv;
            unique case (kind)
                K_ROT:   fill = msbv;
                K_ROX:   fill = x_in;
                default: fill = 1'b0;
            endcase
            nxt = ((val << 1) | W'(fill)) & mask;
        end else begin
            out_bit = val[0];
            unique case (kind)
                K_ASH:   fill = msbv;
                K_ROT:   fill = val[0];
                K_ROX:   fill = x_in;
                default: fill = 1'b0;
            endcase
            nxt = (val >> 1) | (fill ? top : '0);
        end
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [15:0]  opcode,
    input  logic [W-1:0] opd,
    input  logic [W-1:0] cnt_val,
    input  logic [4:0]   ccr_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic [4:0]   ccr_out,
    output logic [2:0]   wb_reg
);
    dec_t             dec;
    logic [CNT_W-1:0] dec_cnt;
    logic             dec_ok;
    logic [W-1:0]     new_mask;

    state_e           state_q, state_d;
    logic [W-1:0]     work_q, orig_q, mask_q;
    logic [CNT_W-1:0] rem_q;
    logic             last_q, x_q, zero_q, left_q;
    kind_e            kind_q;
    logic [2:0]       reg_q;

    logic [W-1:0]     step_nxt;
    logic             step_out;
    logic             accept;
    logic [W-1:0]     top;
    logic             msb_res, msb_org, is_shift;

    shrot_decode #(.W(W), .CNT_W(CNT_W)) u_dec (
        .opcode   (opcode),
        .cnt_val  (cnt_val),
        .dec      (dec),
        .count    (dec_cnt),
        .in_group (dec_ok)
    );

    shrot_mask #(.W(W)) u_mask (
        .size (dec.size),
        .mask (new_mask)
    );

    shrot_step #(.W(W)) u_step (
        .val     (work_q),
        .mask    (mask_q),
        .kind    (kind_q),
        .left    (left_q),
        .x_in    (x_q),
        .nxt     (step_nxt),
        .out_bit (step_out)
    );

    assign accept = (state_q == ST_IDLE) && start && dec_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = (dec_cnt == '0) ? ST_FINISH : ST_STEP;
            ST_STEP:   if (rem_q == CNT_W'(1)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
            orig_q <= '0;
            mask_q <= '0;
            rem_q  <= '0;
            last_q <= 1'b0;
            x_q    <= 1'b0;
            zero_q <= 1'b0;
            left_q <= 1'b0;
            kind_q <= K_ASH;
            reg_q  <= '0;
        end else if (accept) begin
            work_q <= opd & new_mask;
            orig_q <= opd;
            mask_q <= new_mask;
            rem_q  <= dec_cnt;
            last_q <= 1'b0;
            x_q    <= ccr_in[F_X];
            zero_q <= (dec_cnt == '0);
            left_q <= dec.left;
            kind_q <= dec.kind;
            reg_q  <= dec.reg_idx;
        end else if (state_q == ST_STEP) begin
            work_q <= step_nxt;
            last_q <= step_out;
            rem_q  <= rem_q - CNT_W'(1);
            if (kind_q == K_ROX) x_q <= step_out;
        end
    end

    assign top      = mask_q ^ (mask_q >> 1);
    assign msb_res  = |(work_q & top);
    assign msb_org  = |(orig_q & top);
    assign is_shift = (kind_q == K_ASH) || (kind_q == K_LSH);

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FINISH);
        result = (orig_q & ~mask_q) | work_q;
        wb_reg = reg_q;
        ccr_out[F_N] = msb_res;
        ccr_out[F_Z] = (work_q == '0);
        ccr_out[F_V] = (kind_q == K_ASH) && left_q && (msb_res != msb_org);
        unique case (kind_q)
            K_ROX: begin
                ccr_out[F_X] = x_q;
                ccr_out[F_C] = x_q;
            end
            K_ROT: begin
                ccr_out[F_X] = x_q;
                ccr_out[F_C] = !zero_q && last_q;
            end
            default: begin
                ccr_out[F_X] = (is_shift && !zero_q) ? last_q : x_q;
                ccr_out[F_C] = !zero_q && last_q;
            end
        endcase
    end
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk
    import shrot_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [3:0]   op_grp,
    input logic [1:0]   op_size,
    input logic [1:0]   op_kind,
    input logic [W-1:0] opd,
    input logic         x_in,
    input logic [W-1:0] result,
    input logic [4:0]   ccr_out
);
    logic [W-1:0] cap_opd, cap_mask;
    logic [1:0]   cap_kind;
    logic         cap_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_opd  <= '0;
            cap_mask <= '0;
            cap_kind <= 2'b00;
            cap_x    <= 1'b0;
        end else if (start && !busy && op_grp == 4'hE) begin
            cap_opd  <= opd;
            cap_kind <= op_kind;
            cap_x    <= x_in;
            case (op_size)
                2'b00:   cap_mask <= W'(32'h0000_00FF);
                2'b01:   cap_mask <= W'(32'h0000_FFFF);
                default: cap_mask <= {W{1'b1}};
            endcase
        end
    end

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_idle_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_upper_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((result ^ cap_opd) & ~cap_mask) == '0));
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ccr_out[F_Z] == ((result & cap_mask) == '0)));
    p_shift_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_kind == 2'b01) |-> !ccr_out[F_V]);
    p_rot_x_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_kind == 2'b11) |-> (ccr_out[F_X] == cap_x));
    p_rox_cx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_kind == 2'b10) |-> (ccr_out[F_C] == ccr_out[F_X]));
endmodule

bind shrot_unit shrot_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .op_grp  (opcode[15:12]),
    .op_size (opcode[7:6]),
    .op_kind (opcode[4:3]),
    .opd     (opd),
    .x_in    (ccr_in[4]),
    .result  (result),
    .ccr_out (ccr_out)
);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = 16'h0;
    logic [31:0] opd = 32'h0;
    logic [31:0] cnt_val = 32'h0;
    logic [4:0]  ccr_in = 5'h0;
    logic        busy, done;
    logic [31:0] result;
    logic [4:0]  ccr_out;
    logic [2:0]  wb_reg;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  ccr;
        logic [2:0]  wb;
        int          lat;
        int          t0;
        string       tag;
    } item_t;

    item_t sb[$];

    shrot_unit u0 (
        .clk, .rst_n, .start, .opcode, .opd, .cnt_val, .ccr_in,
        .busy, .done, .result, .ccr_out, .wb_reg
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // expected behaviour from the requirements
    function automatic item_t model(input logic [15:0] op, input logic [31:0] d,
                                    input logic [31:0] cv, input logic [4:0] ci);
        item_t r;
        int w, n;
        logic [31:0] m, v, o;
        logic x, outb, last, fill, nf, zf, vf, xf, cf;
        logic [1:0] k;
        k = op[4:3];
        case (op[7:6])
            2'b00:   w = 8;
            2'b01:   w = 16;
            default: w = 32;
        endcase
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        n = op[5] ? int'(cv % 64) : ((op[11:9] == 3'd0) ? 8 : int'(op[11:9]));
        v = d & m; o = v; x = ci[4]; last = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (op[8]) begin
                outb = v[w-1];
                fill = (k == 2'b11) ? outb : (k == 2'b10) ? x : 1'b0;
                v = ((v << 1) | {31'b0, fill}) & m;
            end else begin
                outb = v[0];
                fill = (k == 2'b00) ? v[w-1] : (k == 2'b01) ? 1'b0 : (k == 2'b11) ? outb : x;
                v = v >> 1;
                v[w-1] = fill;
            end
            if (k == 2'b10) x = outb;
            last = outb;
        end
        nf = v[w-1];
        zf = (v == 32'h0);
        vf = (k == 2'b00) && op[8] && (v[w-1] != o[w-1]);
        if (k == 2'b10) begin
            xf = x; cf = x;
        end else if (k == 2'b11) begin
            xf = ci[4]; cf = (n != 0) && last;
        end else begin
            xf = (n == 0) ? ci[4] : last; cf = (n != 0) && last;
        end
        r.res = (d & ~m) | v;
        r.ccr = {xf, nf, zf, vf, cf};
        r.wb  = op[2:0];
        r.lat = n + 1;
        r.t0  = 0;
        r.tag = "";
        return r;
    endfunction

    // driver
    task automatic run(input logic [15:0] op, input logic [31:0] d, input logic [31:0] cv,
                       input logic [4:0] ci, input string tag, input bit poke);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        it = model(op, d, cv, ci);
        it.t0 = cyc;
        it.tag = tag;
        sb.push_back(it);
        opcode = op; opd = d; cnt_val = cv; ccr_in = ci; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R4: start while busy must be ignored
            opcode = 16'hE308; opd = ~d; ccr_in = ~ci; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            opd = d; ccr_in = ci;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4", "unexpected done", result, 32'h0);
            end else begin
                item_t e;
                e = sb.pop_front();
                chk(result == e.res, e.tag, "result", result, e.res);
                chk(ccr_out == e.ccr, e.tag, "ccr", {27'h0, ccr_out}, {27'h0, e.ccr});
                chk(wb_reg == e.wb, "R1", "wb_reg", {29'h0, wb_reg}, {29'h0, e.wb});
                chk((cyc - e.t0) == e.lat, "R4", "latency", cyc - e.t0, e.lat);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R4", "watchdog expired", 32'h0, 32'h0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R11", "busy in reset", {31'h0, busy}, 32'h0);
        chk(done == 1'b0, "R11", "done in reset", {31'h0, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R11", "busy after reset", {31'h0, busy}, 32'h0);

        run(16'hE308, 32'h0000_0001, 32'h0, 5'h1F, "R1/R6 lsl byte 0x01", 1'b0);
        run(16'hE308, 32'h0000_0081, 32'h0, 5'h00, "R6 lsl byte 0x81", 1'b0);
        run(16'hE208, 32'h0000_0081, 32'h0, 5'h00, "R6 lsr byte 0x81", 1'b0);
        run(16'hE300, 32'h5555_5540, 32'h0, 5'h00, "R7 asl overflow", 1'b0);
        run(16'hE640, 32'hABCD_8010, 32'h0, 5'h00, "R3/R7 asr word", 1'b0);
        run(16'hE19A, 32'h1234_5680, 32'h0, 5'h10, "R8/R1 rol long by 8", 1'b0);
        run(16'hE233, 32'hFFFF_FF01, 32'd65, 5'h00, "R9/R2 roxr byte reg 65", 1'b0);
        run(16'hE368, 32'h1234_8000, 32'd64, 5'h13, "R10/R2 lsl zero count", 1'b0);
        run(16'hE330, 32'hAAAA_AA00, 32'd0, 5'h10, "R10 rox zero count", 1'b0);
        run(16'hE2B8, 32'h8000_0001, 32'd40, 5'h0F, "R8 ror long by 40", 1'b0);
        run(16'hE3A9, 32'hFFFF_FFFF, 32'd63, 5'h00, "R6 lsl long by 63", 1'b0);
        run(16'hE2C8, 32'h8000_0001, 32'h0, 5'h00, "R1 size 11 as long", 1'b0);
        run(16'hE150, 32'h0000_C000, 32'h0, 5'h00, "R9 roxl word by 8", 1'b0);
        run(16'hE320, 32'h0000_0081, 32'h0, 5'h10, "R4 ignored start", 1'b1);
        run(16'hE120, 32'h0000_0040, 32'h0, 5'h10, "R4 ignored start zero count", 1'b1);

        // R1: a word outside the shift group is not accepted
        @(negedge clk);
        while (busy) @(negedge clk);
        opcode = 16'h1308; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R1", "non-group start accepted", {31'h0, busy}, 32'h0);

        repeat (80) @(negedge clk);
        chk(sb.size() == 0, "R4", "pending results", sb.size(), 32'h0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule